// File: doc/BRIEF.md
# SPI Command Sequencer

This block carries out one complete SPI master transaction from a single command word. The command has three parts: a two-bit operation code, an offset byte and a byte count. In the two prefixed operations the block first shifts out a register-address byte built from the offset. After that it moves the data bytes. In the two bare operations it moves only the data bytes. Outgoing data is taken from a byte-wide transmit FIFO port, and received data is delivered to a byte-wide receive FIFO port.

The byte count is 12 bits wide, so a single command can move up to 4095 bytes. That is far more than a FIFO beside the block would hold. The sequencer waits, with SCLK idle low and chip select held low, whenever it has no transmit byte or the receiver will not take a received byte. Software can therefore refill or drain the FIFO while the transfer is in progress, and the transfer is never aborted.

The host side uses a command-valid strobe, a busy level, a one-cycle done pulse and a sticky error flag. The serial side is SPI mode 0, MSB first. SCLK runs at the system clock divided by the even parameter `CLK_DIV`.

Top module: `spi_cmd_seq`

## Requirements
- R1: `cmd_op` encoding: bit 1 = bare (no prefix), bit 0 = read. The codes are 0 prefixed write, 1 prefixed read, 2 bare write, 3 bare read. A prefixed operation first sends the address byte {read bit, offset[6:0]}, and only then any data byte.
- R2: A bare operation shifts exactly `cmd_len` data bytes within the chip-select window and sends no address byte.
- R3: Each write data byte is popped from the transmit port with a one-cycle `tx_ready`, which is raised only while `tx_valid` is high, and is sent MSB first. While `tx_valid` is low, the sequencer waits with SCLK low, chip select low and busy high.
- R4: Each read data byte is offered on `rx_data` with `rx_valid`. Both are held unchanged until `rx_ready`, and no further SCLK edge occurs in the meantime. MOSI carries 0x00 during read data bytes.
- R5: SPI mode 0: SCLK idles low and MOSI is stable while SCLK is high. MISO is sampled on the rising edge. Each SCLK high phase lasts `CLK_DIV/2` clock cycles.
- R6: Chip select falls in the cycle after the command is accepted. The first SCLK rising edge comes `CLK_DIV/2 + 1` cycles later. SCLK is high only while chip select is low.
- R7: `done` is a one-cycle pulse. It comes in the same cycle that chip select returns high and `busy` falls.
- R8: A command strobed while busy is ignored, and it does not change the running transfer. It sets `err` in the next cycle, and `err` stays set until the next accepted command clears it.
- R9: A prefixed command with `cmd_len` 0 shifts only the address byte, and delivers no receive byte.
- R10: A bare command with `cmd_len` 0 pulses `done` in the cycle after acceptance, without lowering chip select or raising `busy`.
- R11: Transfers longer than any FIFO, up to 4095 bytes, run to completion with every byte in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_op | input | 2 | Operation code |
| cmd_offset | input | 8 | Address offset for prefixed operations |
| cmd_len | input | LEN_W | Number of data bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky flag: command arrived while busy |
| tx_data | input | 8 | Byte at the head of the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_ready | output | 1 | Pop strobe for the transmit FIFO |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Receive FIFO can accept |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
With `CLK_DIV` 4, chip select is due low at the first falling clock edge after the accepting edge. The first SCLK high is due exactly three falling edges after that, and the high phase lasts exactly two falling edges. The bench drives each command at a falling edge and samples only at falling edges, counting edges from the command strobe, so each of these cycle counts is compared exactly. For a bare zero-length command, `done` is expected at the first falling edge after acceptance and must be gone one edge later. The error flag is expected one edge after the ignored strobe. Stall checks hold the FIFO handshakes off for a fixed number of edges and compare the SCLK rising-edge count before and after.

// File: rtl/sms_pkg.sv
`timescale 1ns/1ps
package sms_pkg;

  typedef enum logic [1:0] {
    OP_PFX_WR  = 2'b00,
    OP_PFX_RD  = 2'b01,
    OP_BARE_WR = 2'b10,
    OP_BARE_RD = 2'b11
  } sms_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_NEXT,
    SQ_SHIFT,
    SQ_PUSH
  } sq_state_e;

  function automatic logic op_is_bare(input sms_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_read(input sms_op_e op);
    return op[0];
  endfunction

  // Address byte: top bit marks a read, lower seven bits from the offset
  function automatic logic [7:0] addr_byte(input sms_op_e op, input logic [7:0] off);
    return {op[0], off[6:0]};
  endfunction

endpackage

// File: rtl/sms_shifter.sv
`timescale 1ns/1ps
// One-byte SPI mode-0 engine: low half, rise (sample), high half, fall (shift)
module sms_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_done
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic          active;
  logic          sclk_q;
  logic [7:0]    sh_tx;
  logic [7:0]    sh_rx;
  logic [2:0]    bit_cnt;
  logic [CW-1:0] tick;
  logic          done_q;
  logic          phase_end;

  assign phase_end = active && (tick == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk_q  <= 1'b0;
      sh_tx   <= 8'h00;
      sh_rx   <= 8'h00;
      bit_cnt <= 3'd0;
      tick    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          sh_tx   <= tx_byte;
          tick    <= '0;
          bit_cnt <= 3'd0;
          sclk_q  <= 1'b0;
        end
      end else if (phase_end) begin
        tick <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          sh_rx  <= {sh_rx[6:0], miso};
        end else begin
          sclk_q  <= 1'b0;
          sh_tx   <= {sh_tx[6:0], 1'b0};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        tick <= tick + CW'(1);
      end
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = sh_tx[7];
  assign rx_byte   = sh_rx;
  assign byte_done = done_q;

endmodule

// File: rtl/sms_remain.sv
`timescale 1ns/1ps
// Remaining data-byte counter
module sms_remain #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - LEN_W'(1);
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/spi_cmd_seq.sv
`timescale 1ns/1ps
module spi_cmd_seq
  import sms_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int LEN_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_offset,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             busy,
  output logic             done,
  output logic             err,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);

  if ((CLK_DIV < 2) || (CLK_DIV % 2 != 0)) begin : g_bad_div
    $error("CLK_DIV must be even and at least 2");
  end

  sq_state_e  state;
  sms_op_e    op_q;
  sms_op_e    op_in;
  logic [7:0] off_q;
  logic       addr_pend;
  logic       cur_data;
  logic       done_q;
  logic       err_q;

  // Named internal events
  logic       accept;
  logic       byte_start;
  logic       byte_done;
  logic       rem_dec;
  logic       rem_zero;
  logic [7:0] start_byte;
  logic [7:0] shift_rx;

  assign op_in  = sms_op_e'(cmd_op);
  assign accept = cmd_valid && (state == SQ_IDLE);

  always_comb begin
    byte_start = 1'b0;
    start_byte = 8'h00;
    rem_dec    = 1'b0;
    tx_ready   = 1'b0;
    if (state == SQ_NEXT) begin
      if (addr_pend) begin
        byte_start = 1'b1;
        start_byte = addr_byte(op_q, off_q);
      end else if (!rem_zero) begin
        if (op_is_read(op_q)) begin
          byte_start = 1'b1;
          rem_dec    = 1'b1;
        end else if (tx_valid) begin
          tx_ready   = 1'b1;
          byte_start = 1'b1;
          start_byte = tx_data;
          rem_dec    = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      op_q      <= OP_PFX_WR;
      off_q     <= 8'h00;
      addr_pend <= 1'b0;
      cur_data  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cmd_valid && (state != SQ_IDLE)) err_q <= 1'b1;
      case (state)
        SQ_IDLE: if (accept) begin
          err_q     <= 1'b0;
          op_q      <= op_in;
          off_q     <= cmd_offset;
          addr_pend <= !op_is_bare(op_in);
          if (op_is_bare(op_in) && (cmd_len == '0)) done_q <= 1'b1;
          else                                      state  <= SQ_NEXT;
        end
        SQ_NEXT: begin
          if (byte_start) begin
            state     <= SQ_SHIFT;
            cur_data  <= !addr_pend;
            addr_pend <= 1'b0;
          end else if (!addr_pend && rem_zero) begin
            state  <= SQ_IDLE;
            done_q <= 1'b1;
          end
        end
        SQ_SHIFT: if (byte_done) begin
          if (cur_data && op_is_read(op_q)) state <= SQ_PUSH;
          else                              state <= SQ_NEXT;
        end
        SQ_PUSH: if (rx_ready) state <= SQ_NEXT;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  sms_remain #(.LEN_W(LEN_W)) u_remain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (cmd_len),
    .dec      (rem_dec),
    .zero     (rem_zero)
  );

  sms_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (byte_start),
    .tx_byte   (start_byte),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .rx_byte   (shift_rx),
    .byte_done (byte_done)
  );

  assign rx_data  = shift_rx;
  assign rx_valid = (state == SQ_PUSH);
  assign busy     = (state != SQ_IDLE);
  assign cs_n     = (state == SQ_IDLE);
  assign done     = done_q;
  assign err      = err_q;

endmodule

// File: rtl/sms_checker.sv
`timescale 1ns/1ps
module sms_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       byte_start,
  input logic       byte_done
);

  AST_TX_POP_GUARD: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> (tx_valid && busy)); // R3
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R4
  AST_RX_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> !sclk); // R4
  AST_MOSI_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi)); // R5
  AST_BYTE_EDGE_LOW: assert property (@(posedge clk) disable iff (!rst_n) (byte_start || byte_done) |-> !sclk); // R5
  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> !cs_n); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cs_n && !busy)); // R7
  AST_ERR_ON_BUSY_CMD: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && busy) |=> err); // R8

endmodule

bind spi_cmd_seq sms_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .cs_n       (cs_n),
  .sclk       (sclk),
  .mosi       (mosi),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .byte_start (byte_start),
  .byte_done  (byte_done)
);

// File: tb/sim_spi_cmd_seq.sv
`timescale 1ns/1ps
module sim_spi_cmd_seq;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;
  localparam int LEN_W   = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [1:0]       cmd_op = 2'd0;
  logic [7:0]       cmd_offset = 8'd0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic             busy, done, err;
  logic [7:0]       tx_data;
  logic             tx_valid, tx_ready;
  logic [7:0]       rx_data;
  logic             rx_valid, rx_ready;
  logic             sclk, mosi, miso, cs_n;

  logic tx_en = 1'b1;
  logic rx_en = 1'b1;
  int   tx_idx = 0;
  int   rx_n = 0;
  logic [7:0] rx_got [0:15];

  int   slv_n = 0;
  int   slv_bits = 0;
  logic [7:0] slv_sh = 8'h00;
  logic [7:0] slv_rx [0:511];
  int   m_idx = 0;
  int   m_bit = 0;
  logic [7:0] m_out = 8'h00;
  int   n_rise = 0;
  int   n_csf = 0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  spi_cmd_seq #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_offset(cmd_offset), .cmd_len(cmd_len), .busy(busy), .done(done),
    .err(err), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  function automatic logic [7:0] txgen(input int k);
    return 8'((k * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 29 + 60) & 255);
  endfunction

  // Transmit FIFO model: endless generated stream
  assign tx_valid = tx_en;
  assign tx_data  = txgen(tx_idx);
  always @(posedge clk) if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;

  // Receive FIFO model
  assign rx_ready = rx_en;
  always @(posedge clk) if (rx_valid && rx_ready) begin
    if (rx_n < 16) rx_got[rx_n] <= rx_data;
    rx_n <= rx_n + 1;
  end

  // SPI slave model, mode 0
  assign miso = m_out[7];
  always @(negedge cs_n) begin
    n_csf = n_csf + 1;
    slv_bits = 0;
    m_idx = 0; m_bit = 0; m_out = pat(0);
  end
  always @(posedge sclk) begin
    n_rise = n_rise + 1;
    if (!cs_n) begin
      slv_sh = {slv_sh[6:0], mosi};
      slv_bits = slv_bits + 1;
      if (slv_bits == 8) begin
        if (slv_n < 512) slv_rx[slv_n] = slv_sh;
        slv_n = slv_n + 1;
        slv_bits = 0;
      end
    end
  end
  always @(negedge sclk) if (!cs_n) begin
    m_bit = m_bit + 1;
    if (m_bit == 8) begin
      m_bit = 0; m_idx = m_idx + 1; m_out = pat(m_idx);
    end else m_out = {m_out[6:0], 1'b0};
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] off, input int len);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_offset = off; cmd_len = LEN_W'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 60000) begin @(negedge clk); t++; end
    check(done == 1'b1, req, done, 1);
    check(cs_n == 1'b1 && busy == 1'b0, "R7 cs/busy at done", {cs_n, busy}, 2'b10);
    @(negedge clk);
    check(done == 1'b0, "R7 done width", done, 0);
  endtask

  task automatic clear_logs();
    @(negedge clk);
    slv_n = 0;
    rx_n <= 0;
  endtask

  task automatic t_reset();
    check(!busy && !done && !err && cs_n && !sclk && !tx_ready && !rx_valid,
          "reset state", {busy, done, err, cs_n, sclk}, 5'b00010);
  endtask

  task automatic t_prefixed_write();
    int base, k, h;
    clear_logs();
    base = tx_idx;
    issue(2'd0, 8'h95, 3);
    check(cs_n == 1'b0, "R6 cs low one cycle after accept", cs_n, 0);
    k = 0;
    while (!sclk && k < 50) begin @(negedge clk); k++; end
    check(k == HALF + 1, "R6 cs-to-first-rise", k, HALF + 1);
    h = 0;
    while (sclk && h < 50) begin @(negedge clk); h++; end
    check(h == HALF, "R5 sclk high width", h, HALF);
    wait_done("R7 done prefixed write");
    check(slv_n == 4, "R1 byte count prefixed write", slv_n, 4);
    check(slv_rx[0] == 8'h15, "R1 address byte write", slv_rx[0], 8'h15);
    for (int i = 0; i < 3; i++)
      check(slv_rx[i+1] == txgen(base + i), "R3 write data", slv_rx[i+1], txgen(base + i));
    check(tx_idx - base == 3, "R3 pop count", tx_idx - base, 3);
  endtask

  task automatic t_prefixed_read();
    clear_logs();
    issue(2'd1, 8'h22, 2);
    wait_done("R7 done prefixed read");
    check(slv_n == 3, "R1 byte count prefixed read", slv_n, 3);
    check(slv_rx[0] == 8'hA2, "R1 address byte read", slv_rx[0], 8'hA2);
    check(slv_rx[1] == 8'h00 && slv_rx[2] == 8'h00, "R4 mosi zero on read", {slv_rx[1], slv_rx[2]}, 0);
    check(rx_n == 2, "R4 rx count", rx_n, 2);
    check(rx_got[0] == pat(1) && rx_got[1] == pat(2), "R4 rx data", {rx_got[0], rx_got[1]}, {pat(1), pat(2)});
  endtask

  task automatic t_bare_write();
    int base;
    clear_logs();
    base = tx_idx;
    issue(2'd2, 8'hFF, 2);
    wait_done("R7 done bare write");
    check(slv_n == 2, "R2 bare write count", slv_n, 2);
    check(slv_rx[0] == txgen(base) && slv_rx[1] == txgen(base + 1), "R2 bare write data",
          {slv_rx[0], slv_rx[1]}, {txgen(base), txgen(base + 1)});
  endtask

  task automatic t_bare_read();
    clear_logs();
    issue(2'd3, 8'h7E, 3);
    wait_done("R7 done bare read");
    check(slv_n == 3, "R2 bare read count", slv_n, 3);
    check(rx_n == 3, "R4 bare read rx count", rx_n, 3);
    for (int i = 0; i < 3; i++)
      check(rx_got[i] == pat(i), "R4 bare read data", rx_got[i], pat(i));
  endtask

  task automatic t_tx_stall();
    int base, r0;
    clear_logs();
    tx_en = 1'b0;
    base = tx_idx;
    r0 = n_rise;
    issue(2'd2, 8'h00, 2);
    repeat (40) @(negedge clk);
    check(n_rise == r0 && !sclk, "R3 no sclk while tx empty", n_rise - r0, 0);
    check(cs_n == 1'b0 && busy == 1'b1, "R3 frame held during stall", {cs_n, busy}, 2'b01);
    tx_en = 1'b1;
    wait_done("R7 done after tx stall");
    check(slv_n == 2 && slv_rx[0] == txgen(base) && slv_rx[1] == txgen(base + 1),
          "R3 data after stall", slv_n, 2);
  endtask

  task automatic t_rx_stall();
    int t, r0;
    logic [7:0] d;
    clear_logs();
    rx_en = 1'b0;
    issue(2'd3, 8'h00, 3);
    t = 0;
    while (!rx_valid && t < 500) begin @(negedge clk); t++; end
    d = rx_data;
    r0 = n_rise;
    repeat (30) @(negedge clk);
    check(rx_valid == 1'b1 && rx_data == d, "R4 rx held while not ready", rx_data, d);
    check(n_rise == r0, "R4 no sclk while rx full", n_rise - r0, 0);
    rx_en = 1'b1;
    wait_done("R7 done after rx stall");
    check(rx_n == 3 && rx_got[0] == pat(0) && rx_got[1] == pat(1) && rx_got[2] == pat(2),
          "R4 rx data after stall", rx_n, 3);
  endtask

  task automatic t_busy_error();
    int base;
    clear_logs();
    base = tx_idx;
    issue(2'd2, 8'h00, 2);
    issue(2'd1, 8'h44, 5);
    check(err == 1'b1, "R8 err set on busy command", err, 1);
    wait_done("R7 done with ignored command");
    check(err == 1'b1, "R8 err sticky", err, 1);
    check(slv_n == 2 && slv_rx[0] == txgen(base) && slv_rx[1] == txgen(base + 1),
          "R8 running transfer unchanged", slv_n, 2);
    clear_logs();
    issue(2'd2, 8'h00, 1);
    check(err == 1'b0, "R8 err cleared by accepted command", err, 0);
    wait_done("R7 done after clear");
  endtask

  task automatic t_prefixed_zero();
    clear_logs();
    issue(2'd1, 8'h05, 0);
    wait_done("R7 done prefixed zero");
    check(slv_n == 1 && slv_rx[0] == 8'h85, "R9 only address byte", slv_rx[0], 8'h85);
    check(rx_n == 0, "R9 no rx byte", rx_n, 0);
  endtask

  task automatic t_bare_zero();
    int c0;
    clear_logs();
    c0 = n_csf;
    issue(2'd3, 8'h00, 0);
    check(done == 1'b1 && busy == 1'b0 && cs_n == 1'b1, "R10 immediate done", {done, busy, cs_n}, 3'b101);
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", done, 0);
    check(n_csf == c0 && slv_n == 0, "R10 no chip select", n_csf - c0, 0);
  endtask

  task automatic t_long();
    int base, bad;
    clear_logs();
    base = tx_idx;
    issue(2'd2, 8'h00, 300);
    wait_done("R7 done long");
    check(slv_n == 300, "R11 long count", slv_n, 300);
    bad = 0;
    for (int i = 0; i < 300; i++) if (slv_rx[i] != txgen(base + i)) bad++;
    check(bad == 0, "R11 long data order", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prefixed_write();
    t_prefixed_read();
    t_bare_write();
    t_bare_read();
    t_tx_stall();
    t_rx_stall();
    t_busy_error();
    t_prefixed_zero();
    t_bare_zero();
    t_long();
    repeat (5) @(negedge clk);
    report();
  end

endmodule